// File: doc/BRIEF.md
# Per-Device Key Provisioning Sequencer

This block runs once per board on the manufacturing line. It loads a device-unique authentication key into an external secure memory. A rising edge on the program input starts one attempt. The block asks the memory for its 64-bit serial number, which comes back as a stream of bytes, and assembles the full word. It then hands the serial number and a built-in master key to a hash engine. The hash result is the device key. The block writes that key to the memory and then asks the memory for a status byte. The pass output rises only when that status byte reports success.

Both the serial-wire signalling and the hash computation sit outside this block. It reaches the memory through a command port (valid/ready, with an opcode and a data word) and a byte-wide response port. It reaches the hash engine through a request/done handshake. Because the device key is derived from the serial number, no two memories hold the same key, and the master key never leaves the chip. The master key is fixed when the design is built. The default value is only a placeholder and must be replaced.

Top module: `keyprov_seq`

## Requirements
- R1: A rising edge on `prog_i`, seen while no attempt is running, starts an attempt. In the next cycle the block presents a serial-read command (`cmd_op_o` = 2'd1) on the command port, which stays valid until `cmd_ready_i` accepts it.
- R2: `pass_o` goes high in the cycle after the block accepts a status byte equal to `STATUS_OK` (default 8'hAA). It stays high until the next start or reset.
- R3: A status byte with any value other than `STATUS_OK` ends the attempt with `pass_o` low.
- R4: The serial number arrives as `SN_W/BYTE_W` response bytes. The first byte lands in bits [7:0], the next in [15:8], and so on. `hash_req_o` is raised only after the last byte is captured, and it presents the assembled serial on `hash_sn_o`.
- R5: After `hash_done_i`, the block issues a write command (`cmd_op_o` = 2'd2) carrying `hash_result_i`, never the raw master key. It then issues a status-read command (`cmd_op_o` = 2'd3). A command held without ready keeps its opcode and data stable.
- R6: If an attempt sees no progress for `TIMEOUT_CYC` consecutive cycles, it is abandoned. Progress means a state change or an accepted response byte. The block returns to idle with `pass_o` low.
- R7: Starting a new attempt clears `pass_o` in the cycle after the edge, and the whole sequence runs again.
- R8: A `prog_i` edge that arrives while an attempt is running is ignored. This includes an edge in the same cycle as the final status byte. No extra serial-read command follows.
- R9: Active-high synchronous `rst` returns the block to idle. `pass_o` is low, and no command or hash request is raised.
- R10: The key sent on `hash_key_o` is the `MASTER_KEY` parameter, whose default is 64'h0123456789ABCDEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_i | input | 1 | Program request, rising edge starts an attempt |
| pass_o | output | 1 | High after a confirmed key store |
| cmd_valid_o | output | 1 | Memory command valid |
| cmd_ready_i | input | 1 | Memory command accepted |
| cmd_op_o | output | 2 | Opcode: 1 read serial, 2 write key, 3 read status |
| cmd_data_o | output | KEY_W | Key word for the write command, zero otherwise |
| rsp_valid_i | input | 1 | Response byte valid |
| rsp_data_i | input | BYTE_W | Response byte |
| hash_req_o | output | 1 | Hash request, held until done |
| hash_done_i | input | 1 | Hash result valid |
| hash_key_o | output | KEY_W | Master key for the hash |
| hash_sn_o | output | SN_W | Assembled serial number for the hash |
| hash_result_i | input | KEY_W | Derived device key |

## Verification
Two things can land on the same clock edge: the final status byte that ends an attempt, and a fresh rising edge on `prog_i`. The bench provokes this by having its memory responder raise `prog_i` in exactly the cycle it drives the status byte. It then checks three things: `pass_o` reflects that byte, the block settles back to idle, and no second serial-read command appears. A behavioural reference model tracks every cycle, including byte gaps, hash latency and timeouts, and is compared against all outputs each clock.

// File: rtl/keyprov_pkg.sv
package keyprov_pkg;

   // Opcode values on the memory command port
   localparam logic [1:0] OP_NONE      = 2'd0;
   localparam logic [1:0] OP_READ_SN   = 2'd1;
   localparam logic [1:0] OP_WRITE_KEY = 2'd2;
   localparam logic [1:0] OP_READ_STAT = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SN_CMD,
      ST_SN_RX,
      ST_HASH,
      ST_WR_CMD,
      ST_STAT_CMD,
      ST_STAT_RX
   } seq_state_e;

endpackage

// File: rtl/keyprov_edge.sv
// Rising-edge detector with an optional synchroniser chain on the input.
module keyprov_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic level_i,
   output logic rise_o
);
   logic lvl_s;
   logic lvl_q;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_stages
         $error("keyprov_edge: SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl_s = level_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= SYNC_STAGES'({sh_q, level_i});
         end
         assign lvl_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= 1'b0;
      else     lvl_q <= lvl_s;
   end

   assign rise_o = lvl_s & ~lvl_q;
endmodule

// File: rtl/keyprov_assembler.sv
// Collects a word from consecutive lanes, lowest lane first.
module keyprov_assembler #(
   parameter int WORD_W = 64,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear_i,
   input  logic              take_i,
   input  logic [LANE_W-1:0] lane_i,
   output logic              last_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int LANES = WORD_W / LANE_W;
   localparam int CNT_W = $clog2(LANES + 1);

   generate
      if (WORD_W % LANE_W != 0) begin : g_bad_split
         $error("keyprov_assembler: WORD_W must be a multiple of LANE_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clear_i)
         cnt_q <= '0;
      else if (take_i && cnt_q != CNT_W'(LANES))
         cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == CNT_W'(LANES - 1));

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] lane_q;
         always_ff @(posedge clk) begin
            if (rst)
               lane_q <= '0;
            else if (take_i && cnt_q == CNT_W'(g))
               lane_q <= lane_i;
         end
         assign word_o[g*LANE_W +: LANE_W] = lane_q;
      end
   endgenerate
endmodule

// File: rtl/keyprov_timer.sv
// Idle-progress watchdog: fires after LIMIT cycles without a restart.
module keyprov_timer #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   input  logic restart_i,
   output logic expire_o
);
   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("keyprov_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign expire_o = run_i && !restart_i && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (rst || !run_i || restart_i || expire_o)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/keyprov_seq.sv
module keyprov_seq
   import keyprov_pkg::*;
#(
   parameter int                KEY_W       = 64,
   parameter int                SN_W        = 64,
   parameter int                BYTE_W      = 8,
   parameter logic [KEY_W-1:0]  MASTER_KEY  = 64'h0123_4567_89AB_CDEF,
   parameter logic [BYTE_W-1:0] STATUS_OK   = 8'hAA,
   parameter int                TIMEOUT_CYC = 4096,
   parameter int                SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              prog_i,
   output logic              pass_o,
   output logic              cmd_valid_o,
   input  logic              cmd_ready_i,
   output logic [1:0]        cmd_op_o,
   output logic [KEY_W-1:0]  cmd_data_o,
   input  logic              rsp_valid_i,
   input  logic [BYTE_W-1:0] rsp_data_i,
   output logic              hash_req_o,
   input  logic              hash_done_i,
   output logic [KEY_W-1:0]  hash_key_o,
   output logic [SN_W-1:0]   hash_sn_o,
   input  logic [KEY_W-1:0]  hash_result_i
);
   localparam int SN_BYTES = SN_W / BYTE_W;

   generate
      if (SN_W % BYTE_W != 0) begin : g_bad_sn
         $error("keyprov_seq: SN_W must be a multiple of BYTE_W");
      end
      if (SN_BYTES < 1) begin : g_bad_bytes
         $error("keyprov_seq: serial must span at least one byte");
      end
      if (KEY_W < 1) begin : g_bad_key
         $error("keyprov_seq: KEY_W must be positive");
      end
   endgenerate

   seq_state_e       st_q, st_raw, st_nxt;
   logic             start_rise;
   logic             seq_idle;
   logic             sn_take, sn_last;
   logic             byte_take;
   logic             progress;
   logic             tmo_hit;
   logic [SN_W-1:0]  sn_word;
   logic [KEY_W-1:0] dev_key_q;
   logic             pass_q;

   keyprov_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst     (rst),
      .level_i (prog_i),
      .rise_o  (start_rise)
   );

   assign seq_idle  = (st_q == ST_IDLE);
   assign sn_take   = rsp_valid_i && (st_q == ST_SN_RX);
   assign byte_take = sn_take || (rsp_valid_i && st_q == ST_STAT_RX);

   keyprov_assembler #(.WORD_W(SN_W), .LANE_W(BYTE_W)) u_asm (
      .clk     (clk),
      .rst     (rst),
      .clear_i (seq_idle),
      .take_i  (sn_take),
      .lane_i  (rsp_data_i),
      .last_o  (sn_last),
      .word_o  (sn_word)
   );

   // Nominal next state, ignoring the watchdog
   always_comb begin
      st_raw = st_q;
      case (st_q)
         ST_IDLE:     if (start_rise)          st_raw = ST_SN_CMD;
         ST_SN_CMD:   if (cmd_ready_i)         st_raw = ST_SN_RX;
         ST_SN_RX:    if (sn_take && sn_last)  st_raw = ST_HASH;
         ST_HASH:     if (hash_done_i)         st_raw = ST_WR_CMD;
         ST_WR_CMD:   if (cmd_ready_i)         st_raw = ST_STAT_CMD;
         ST_STAT_CMD: if (cmd_ready_i)         st_raw = ST_STAT_RX;
         ST_STAT_RX:  if (rsp_valid_i)         st_raw = ST_IDLE;
         default:                              st_raw = ST_IDLE;
      endcase
   end

   assign progress = (st_raw != st_q) || byte_take;

   keyprov_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
      .clk       (clk),
      .rst       (rst),
      .run_i     (!seq_idle),
      .restart_i (progress),
      .expire_o  (tmo_hit)
   );

   assign st_nxt = tmo_hit ? ST_IDLE : st_raw;

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_nxt;
   end

   always_ff @(posedge clk) begin
      if (rst)
         dev_key_q <= '0;
      else if (st_q == ST_HASH && hash_done_i)
         dev_key_q <= hash_result_i;
   end

   always_ff @(posedge clk) begin
      if (rst)
         pass_q <= 1'b0;
      else if (seq_idle && start_rise)
         pass_q <= 1'b0;
      else if (st_q == ST_STAT_RX && rsp_valid_i)
         pass_q <= (rsp_data_i == STATUS_OK);
   end

   always_comb begin
      cmd_valid_o = 1'b0;
      cmd_op_o    = OP_NONE;
      cmd_data_o  = '0;
      case (st_q)
         ST_SN_CMD: begin
            cmd_valid_o = 1'b1;
            cmd_op_o    = OP_READ_SN;
         end
         ST_WR_CMD: begin
            cmd_valid_o = 1'b1;
            cmd_op_o    = OP_WRITE_KEY;
            cmd_data_o  = dev_key_q;
         end
         ST_STAT_CMD: begin
            cmd_valid_o = 1'b1;
            cmd_op_o    = OP_READ_STAT;
         end
         default: ;
      endcase
   end

   assign hash_req_o = (st_q == ST_HASH);
   assign hash_key_o = MASTER_KEY;
   assign hash_sn_o  = sn_word;
   assign pass_o     = pass_q;
endmodule

// File: rtl/keyprov_seq_chk.sv
module keyprov_seq_chk #(
   parameter int                KEY_W     = 64,
   parameter int                SN_W      = 64,
   parameter int                BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] STATUS_OK = 8'hAA
) (
   input logic              clk,
   input logic              rst,
   input logic              prog_i,
   input logic              pass_o,
   input logic              cmd_valid_o,
   input logic              cmd_ready_i,
   input logic [1:0]        cmd_op_o,
   input logic [KEY_W-1:0]  cmd_data_o,
   input logic              rsp_valid_i,
   input logic [BYTE_W-1:0] rsp_data_i,
   input logic              hash_req_o,
   input logic [SN_W-1:0]   hash_sn_o,
   input logic              idle,
   input logic              tmo_hit
);
   // R1 / R8: a serial-read command only follows an edge seen in idle
   p_start_from_idle_r1: assert property (@(posedge clk) disable iff (rst)
      ($rose(cmd_valid_o) && cmd_op_o == 2'd1) |-> $past(idle && prog_i));

   // R2: pass rises only after an accepted good status byte
   p_pass_needs_ok_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(pass_o) |-> $past(rsp_valid_i && rsp_data_i == STATUS_OK));

   // R7: a new attempt starts with pass cleared
   p_pass_cleared_r7: assert property (@(posedge clk) disable iff (rst)
      ($rose(cmd_valid_o) && cmd_op_o == 2'd1) |-> !pass_o);

   // R4: serial presented to the hash engine does not move during a request
   p_sn_stable_r4: assert property (@(posedge clk) disable iff (rst)
      (hash_req_o && $past(hash_req_o)) |-> $stable(hash_sn_o));

   // R5: an unaccepted command holds its content
   p_cmd_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid_o && !cmd_ready_i && !tmo_hit) |=>
         (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o)));

   // R6: a watchdog expiry abandons the attempt with pass low
   p_abort_r6: assert property (@(posedge clk) disable iff (rst)
      tmo_hit |=> (idle && !pass_o && !cmd_valid_o && !hash_req_o));

   // R9: outputs quiet right after reset
   p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!pass_o && !cmd_valid_o && !hash_req_o));
endmodule

bind keyprov_seq keyprov_seq_chk #(
   .KEY_W     (KEY_W),
   .SN_W      (SN_W),
   .BYTE_W    (BYTE_W),
   .STATUS_OK (STATUS_OK)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .prog_i      (prog_i),
   .pass_o      (pass_o),
   .cmd_valid_o (cmd_valid_o),
   .cmd_ready_i (cmd_ready_i),
   .cmd_op_o    (cmd_op_o),
   .cmd_data_o  (cmd_data_o),
   .rsp_valid_i (rsp_valid_i),
   .rsp_data_i  (rsp_data_i),
   .hash_req_o  (hash_req_o),
   .hash_sn_o   (hash_sn_o),
   .idle        (seq_idle),
   .tmo_hit     (tmo_hit)
);

// File: tb/keyprov_seq_tb_top.sv
module keyprov_seq_tb_top;
   localparam int          TMO  = 24;
   localparam logic [63:0] MKEY = 64'h0123_4567_89AB_CDEF;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        prog_i = 1'b0;
   logic        pass_o;
   logic        cmd_valid_o;
   logic        cmd_ready_i = 1'b0;
   logic [1:0]  cmd_op_o;
   logic [63:0] cmd_data_o;
   logic        rsp_valid_i = 1'b0;
   logic [7:0]  rsp_data_i = 8'h00;
   logic        hash_req_o;
   logic        hash_done_i = 1'b0;
   logic [63:0] hash_key_o;
   logic [63:0] hash_sn_o;
   logic [63:0] hash_result_i = 64'h0;

   keyprov_seq #(.TIMEOUT_CYC(TMO)) dut_i (
      .clk(clk), .rst(rst), .prog_i(prog_i), .pass_o(pass_o),
      .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
      .cmd_op_o(cmd_op_o), .cmd_data_o(cmd_data_o),
      .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
      .hash_req_o(hash_req_o), .hash_done_i(hash_done_i),
      .hash_key_o(hash_key_o), .hash_sn_o(hash_sn_o),
      .hash_result_i(hash_result_i)
   );

   always #10ns clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mix(input logic [63:0] k, input logic [63:0] s);
      return {k[31:0] ^ s[63:32], k[63:32] ^ s[31:0]} + 64'h9E37_79B9_7F4A_7C15;
   endfunction

   // ---------------- environment configuration (set by the test) ------------
   logic [63:0] sn_val   = 64'h0;
   logic [7:0]  stat_val = 8'hAA;
   int          sn_send  = 8;
   bit          stat_en  = 1'b1;
   bit          gap      = 1'b0;
   int          hash_lat = 0;
   bit          collide  = 1'b0;
   bit          prog_lvl = 1'b0;

   // observations
   int          n_sn = 0, n_wr = 0, n_st = 0, n_hash = 0;
   logic [63:0] wr_seen = 0, hkey_seen = 0, hsn_seen = 0;

   // ---------------- memory and hash responder (negedge) --------------------
   int          sn_left = 0, sn_idx = 0, hash_cnt = 0;
   bit          st_pend = 1'b0, gap_tog = 1'b0;
   logic [1:0]  rdy_op = 2'd0;
   logic [63:0] rdy_data = 64'h0;

   always @(negedge clk) begin
      if (rst) begin
         cmd_ready_i = 1'b0; rsp_valid_i = 1'b0; hash_done_i = 1'b0;
         sn_left = 0; sn_idx = 0; st_pend = 1'b0; hash_cnt = 0; gap_tog = 1'b0;
         prog_i = prog_lvl;
      end else begin
         bit coll_now;
         coll_now = 1'b0;
         if (cmd_ready_i) begin
            case (rdy_op)
               2'd1: begin n_sn++; sn_left = sn_send; sn_idx = 0; gap_tog = 1'b0; end
               2'd2: begin n_wr++; wr_seen = rdy_data; end
               2'd3: begin n_st++; st_pend = stat_en; end
               default: ;
            endcase
         end
         rsp_valid_i = 1'b0;
         if (sn_left > 0) begin
            if (!gap || !gap_tog) begin
               rsp_valid_i = 1'b1;
               rsp_data_i  = sn_val[8*sn_idx +: 8];
               sn_idx++;
               sn_left--;
            end
            gap_tog = !gap_tog;
         end else if (st_pend) begin
            rsp_valid_i = 1'b1;
            rsp_data_i  = stat_val;
            st_pend     = 1'b0;
            if (collide) begin coll_now = 1'b1; collide = 1'b0; end
         end
         hash_done_i = 1'b0;
         if (!hash_req_o) hash_cnt = 0;
         else if (hash_cnt == hash_lat) begin
            hash_done_i   = 1'b1;
            hash_result_i = mix(hash_key_o, hash_sn_o);
            hkey_seen     = hash_key_o;
            hsn_seen      = hash_sn_o;
            n_hash++;
            hash_cnt = 0;
         end else hash_cnt++;
         cmd_ready_i = cmd_valid_o;
         rdy_op      = cmd_op_o;
         rdy_data    = cmd_data_o;
         prog_i      = prog_lvl | coll_now;
      end
   end

   // ---------------- behavioural reference model (posedge) ------------------
   // phase: 0 idle, 1 serial cmd, 2 serial bytes, 3 hash, 4 write, 5 status cmd, 6 status byte
   int          m_phase = 0, m_wait = 0;
   bit          m_pass = 1'b0, m_prev = 1'b0;
   logic [7:0]  m_q[$];
   logic [63:0] m_key = 64'h0;

   always @(posedge clk) begin
      if (rst) begin
         m_phase = 0; m_wait = 0; m_pass = 1'b0; m_prev = 1'b0; m_q.delete(); m_key = 64'h0;
      end else begin
         int nxt;
         bit prog;
         nxt  = m_phase;
         prog = 1'b0;
         case (m_phase)
            0: if (prog_i && !m_prev) begin nxt = 1; m_pass = 1'b0; m_q.delete(); end
            1: if (cmd_ready_i) nxt = 2;
            2: if (rsp_valid_i) begin
                  m_q.push_back(rsp_data_i); prog = 1'b1;
                  if (m_q.size() == 8) nxt = 3;
               end
            3: if (hash_done_i) begin m_key = hash_result_i; nxt = 4; end
            4: if (cmd_ready_i) nxt = 5;
            5: if (cmd_ready_i) nxt = 6;
            6: if (rsp_valid_i) begin m_pass = (rsp_data_i == 8'hAA); nxt = 0; end
            default: nxt = 0;
         endcase
         if (m_phase != 0) begin
            if (nxt != m_phase || prog) m_wait = 0;
            else if (m_wait == TMO - 1) begin nxt = 0; m_wait = 0; end
            else m_wait++;
         end
         m_prev  = prog_i;
         m_phase = nxt;
      end
   end

   // ---------------- per-cycle comparison (negedge) -------------------------
   always @(negedge clk) begin
      if (!rst && !done) begin
         bit          ev;
         logic [63:0] esn;
         logic [1:0]  eop;
         ev  = (m_phase == 1 || m_phase == 4 || m_phase == 5);
         eop = (m_phase == 1) ? 2'd1 : (m_phase == 4) ? 2'd2 : 2'd3;
         esn = 64'h0;
         foreach (m_q[i]) esn[8*i +: 8] = m_q[i];
         chk(pass_o === m_pass, "R2 pass per cycle", 64'(pass_o), 64'(m_pass));
         chk(cmd_valid_o === ev, "R1 cmd_valid per cycle", 64'(cmd_valid_o), 64'(ev));
         if (ev) chk(cmd_op_o === eop, "R5 opcode", 64'(cmd_op_o), 64'(eop));
         if (m_phase == 4) chk(cmd_data_o === m_key, "R5 write data", cmd_data_o, m_key);
         chk(hash_req_o === (m_phase == 3), "R4 hash_req per cycle", 64'(hash_req_o), 64'(m_phase == 3));
         if (m_phase == 3) begin
            chk(hash_sn_o === esn, "R4 assembled serial", hash_sn_o, esn);
            chk(hash_key_o === MKEY, "R10 master key", hash_key_o, MKEY);
         end
      end
   end

   // ---------------- stimulus -----------------------------------------------
   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #5ns; end
   endtask

   task automatic start_seq();
      prog_lvl = 1'b1;
      @(posedge clk); #5ns;
      prog_lvl = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400; i++) begin
         if (m_phase == 0) break;
         cyc(1);
      end
      cyc(2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      int b_sn, b_wr, b_st, b_hash;
      cyc(3);
      rst = 1'b0;
      cyc(1);
      // R9: reset state
      chk(pass_o == 1'b0, "R9 pass after reset", 64'(pass_o), 64'd0);
      chk(cmd_valid_o == 1'b0, "R9 no command after reset", 64'(cmd_valid_o), 64'd0);
      chk(hash_req_o == 1'b0, "R9 no hash after reset", 64'(hash_req_o), 64'd0);

      // Normal attempt
      sn_val = 64'h1122_3344_5566_7788; stat_val = 8'hAA; hash_lat = 2;
      b_sn = n_sn;
      start_seq();
      wait_idle();
      chk(pass_o == 1'b1, "R2 pass after good status", 64'(pass_o), 64'd1);
      chk(wr_seen == mix(MKEY, sn_val), "R5 written key is hash", wr_seen, mix(MKEY, sn_val));
      chk(wr_seen != MKEY, "R5 raw key not written", wr_seen, ~MKEY);
      chk(hsn_seen == sn_val, "R4 serial byte order", hsn_seen, sn_val);
      chk(hkey_seen == 64'h0123_4567_89AB_CDEF, "R10 default key", hkey_seen, 64'h0123_4567_89AB_CDEF);
      chk(n_sn - b_sn == 1, "R1 one serial read", 64'(n_sn - b_sn), 64'd1);

      // Rerun with bad status: pass clears at start, stays low
      sn_val = 64'hA5A5_0F0F_C3C3_9669; stat_val = 8'h55; b_wr = n_wr;
      start_seq();
      chk(pass_o == 1'b0, "R7 pass cleared on restart", 64'(pass_o), 64'd0);
      wait_idle();
      chk(pass_o == 1'b0, "R3 bad status keeps pass low", 64'(pass_o), 64'd0);
      chk(n_wr - b_wr == 1, "R5 write issued", 64'(n_wr - b_wr), 64'd1);

      // Gapped bytes, slow hash, edge while busy
      sn_val = 64'hDEAD_BEEF_0BAD_F00D; stat_val = 8'hAA; gap = 1'b1; hash_lat = 5;
      b_sn = n_sn;
      start_seq();
      cyc(6);
      start_seq();
      wait_idle();
      chk(n_sn - b_sn == 1, "R8 busy edge ignored", 64'(n_sn - b_sn), 64'd1);
      chk(pass_o == 1'b1, "R2 pass after gapped run", 64'(pass_o), 64'd1);
      chk(hsn_seen == sn_val, "R4 gapped serial", hsn_seen, sn_val);
      gap = 1'b0; hash_lat = 0;

      // Edge in the same cycle as the final status byte
      sn_val = 64'h0000_0000_0000_00FF; collide = 1'b1; b_sn = n_sn;
      start_seq();
      wait_idle();
      cyc(5);
      chk(n_sn - b_sn == 1, "R8 collision edge ignored", 64'(n_sn - b_sn), 64'd1);
      chk(cmd_valid_o == 1'b0, "R8 idle after collision", 64'(cmd_valid_o), 64'd0);
      chk(pass_o == 1'b1, "R2 pass after collision", 64'(pass_o), 64'd1);

      // No status reply: timeout
      stat_en = 1'b0; b_st = n_st;
      start_seq();
      wait_idle();
      chk(pass_o == 1'b0, "R6 timeout leaves pass low", 64'(pass_o), 64'd0);
      chk(n_st - b_st == 1, "R6 status was requested", 64'(n_st - b_st), 64'd1);
      chk(cmd_valid_o == 1'b0, "R6 idle after timeout", 64'(cmd_valid_o), 64'd0);
      stat_en = 1'b1;

      // Short serial: no hash request, timeout
      sn_send = 5; b_hash = n_hash;
      start_seq();
      wait_idle();
      chk(n_hash == b_hash, "R4 no hash on short serial", 64'(n_hash - b_hash), 64'd0);
      chk(pass_o == 1'b0, "R6 short serial fails", 64'(pass_o), 64'd0);
      sn_send = 8;

      // Reset in mid-sequence, then recovery
      sn_val = 64'h7766_5544_3322_1100;
      start_seq();
      cyc(12);
      rst = 1'b1;
      cyc(2);
      rst = 1'b0;
      cyc(1);
      chk(pass_o == 1'b0, "R9 pass after mid reset", 64'(pass_o), 64'd0);
      chk(cmd_valid_o == 1'b0 && hash_req_o == 1'b0, "R9 quiet after mid reset",
          64'({cmd_valid_o, hash_req_o}), 64'd0);
      start_seq();
      wait_idle();
      chk(pass_o == 1'b1, "R1 restart after reset", 64'(pass_o), 64'd1);

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule